// File: doc/BRIEF.md
# Parameterized Floating-Point Adder Pipeline

This block adds or subtracts two numbers held in a floating-point format whose exponent and fraction widths are both parameters. A word is packed as sign, exponent, fraction from the most significant bit down. A nonzero word stands for (-1)^s × 1.f × 2^(e − BIAS), where BIAS = 2^(EXP_W−1) − 1. A word with exponent zero is taken as zero, whatever its fraction holds. IEEE single precision is the case EXP_W=8, MAN_W=23. The default here is a 12-bit format with EXP_W=5 and MAN_W=6.

The pipeline has three parts. A combinational unpack restores the hidden digit of each operand. A four-register align/add section orders the operands by magnitude, shifts the smaller one right and adds or subtracts the two. A two-register round/normalize section brings the sum back to packed form. A new operation may enter on every clock. A strobe and an exception flag travel with each operation, so the result comes out with its own strobe six clocks after the operation enters. Subtraction is an addition with the second operand's sign inverted. Overflow and underflow show only on the exception output.

Top module: `fpadd_pipe`

## Requirements
- R1: For nonzero, non-overflowing operands, the sum equals the exact sum rounded to MAN_W fraction bits in the selected mode. The result is packed as {sign, exponent, fraction} with BIAS = 2^(EXP_W−1)−1.
- R2: An operand whose exponent field is 0 counts as zero, and its fraction and sign are ignored. When both operands are such zeros, the result is the all-zero word.
- R3: done_o is high exactly 6 clocks after the clock that captures ready_i high, once for each accepted operation. Operations can be accepted on consecutive clocks.
- R4: With rnd_i=0 (toward zero), the magnitude is truncated to MAN_W fraction bits.
- R5: With rnd_i=1 (nearest), the magnitude rounds to the nearest representable value. An exact half rounds to the neighbour whose fraction LSB is 0.
- R6: With sub_i=1, the result is op_a_i − op_b_i.
- R7: An exact cancellation gives the all-zero word (+0, exponent 0). This alone does not raise exc_o.
- R8: If the normalized exponent of a nonzero result is below 1, the result is the all-zero word and exc_o is 1.
- R9: If the rounded exponent is above 2^EXP_W−1, the result keeps its sign, sets the exponent and fraction fields to all ones, and sets exc_o to 1.
- R10: exc_i=1 on an accepted operation makes exc_o=1 on that operation's result.
- R11: While rst is high, and on the clock after, done_o and exc_o are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_i | input | 1 | Operation valid strobe |
| exc_i | input | 1 | Exception flag carried with the operation |
| sub_i | input | 1 | 1 = subtract op_b_i from op_a_i |
| rnd_i | input | 1 | Rounding mode: 0 toward zero, 1 nearest-even |
| op_a_i | input | 1+EXP_W+MAN_W | First operand {sign, exponent, fraction} |
| op_b_i | input | 1+EXP_W+MAN_W | Second operand {sign, exponent, fraction} |
| done_o | output | 1 | Result valid strobe |
| exc_o | output | 1 | Exception flag of the result |
| sum_o | output | 1+EXP_W+MAN_W | Packed result |

## Verification
Each stage has no stall and no feedback, so a fault in one stage's data register shows up in the sum_o of the operation holding that slot, six clocks after the operation enters. Errors in these areas each give a wrong word for the operation concerned:
- a wrong operand swap, alignment shift or sticky bit;
- a wrong leading-zero count, or the exponent correction that goes with it;
- a wrong round increment, or the carry out of rounding.

A lost or extra valid bit shows as a missing or extra done_o pulse at that same clock. A lost exception bit shows on exc_o at the same point. Each operation is checked against a model computed exactly on integers, including latency, half-way ties, cancellation, flush and saturation.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  typedef enum logic {
    RND_ZERO = 1'b0,
    RND_NEAR = 1'b1
  } rnd_mode_e;

  // extra low-order bits kept during alignment: guard, round, sticky
  localparam int GRS_W = 3;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input  logic [EXP_W+MAN_W:0] op_i,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W:0]       mant_o
);
  logic nz;

  assign sign_o = op_i[EXP_W+MAN_W];
  assign exp_o  = op_i[EXP_W+MAN_W-1:MAN_W];
  assign nz     = |exp_o;
  // hidden digit is 1 for normal values; a zero exponent clears everything
  assign mant_o = {nz, op_i[MAN_W-1:0] & {MAN_W{nz}}};
endmodule

// File: rtl/fpadd_align_add.sv
module fpadd_align_add
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic                 exc_i,
  input  logic                 rnd_i,
  input  logic                 sa_i,
  input  logic [EXP_W-1:0]     ea_i,
  input  logic [MAN_W:0]       ma_i,
  input  logic                 sb_i,
  input  logic [EXP_W-1:0]     eb_i,
  input  logic [MAN_W:0]       mb_i,
  output logic                 vld_o,
  output logic                 exc_o,
  output logic                 rnd_o,
  output logic                 sign_o,
  output logic [EXP_W-1:0]     exp_o,
  output logic [MAN_W+GRS_W+1:0] sum_o
);
  localparam int WM = MAN_W + 1;
  localparam int WA = WM + GRS_W;
  localparam int WS = WA + 1;

  // stage 1: order by magnitude
  logic           a_ge;
  logic           s1_v, s1_x, s1_r, s1_ls, s1_sub;
  logic [EXP_W-1:0] s1_le, s1_d;
  logic [WM-1:0]  s1_lm, s1_sm;

  assign a_ge = {ea_i, ma_i} >= {eb_i, mb_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s1_x <= 1'b0;
    end else begin
      s1_v <= vld_i;
      s1_x <= vld_i & exc_i;
    end
    s1_r   <= rnd_i;
    s1_sub <= sa_i ^ sb_i;
    s1_ls  <= a_ge ? sa_i : sb_i;
    s1_le  <= a_ge ? ea_i : eb_i;
    s1_lm  <= a_ge ? ma_i : mb_i;
    s1_sm  <= a_ge ? mb_i : ma_i;
    s1_d   <= a_ge ? (ea_i - eb_i) : (eb_i - ea_i);
  end

  // stage 2: align the smaller operand, folding lost bits into sticky
  logic [WA-1:0]  ext, al_c, lost_mask;
  logic           s2_v, s2_x, s2_r, s2_ls, s2_sub;
  logic [EXP_W-1:0] s2_le;
  logic [WM-1:0]  s2_lm;
  logic [WA-1:0]  s2_al;

  always_comb begin
    ext       = {s1_sm, {GRS_W{1'b0}}};
    lost_mask = ~({WA{1'b1}} << s1_d);
    if (int'(s1_d) >= WA) begin
      al_c = {{(WA-1){1'b0}}, |s1_sm};
    end else begin
      al_c    = ext >> s1_d;
      al_c[0] = al_c[0] | (|(ext & lost_mask));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
      s2_x <= 1'b0;
    end else begin
      s2_v <= s1_v;
      s2_x <= s1_x;
    end
    s2_r   <= s1_r;
    s2_sub <= s1_sub;
    s2_ls  <= s1_ls;
    s2_le  <= s1_le;
    s2_lm  <= s1_lm;
    s2_al  <= al_c;
  end

  // stage 3: add or subtract magnitudes (larger minus smaller never goes negative)
  logic [WS-1:0]  lx, sx, sum_c;
  logic           s3_v, s3_x, s3_r, s3_ls;
  logic [EXP_W-1:0] s3_le;
  logic [WS-1:0]  s3_sum;

  assign lx    = {1'b0, s2_lm, {GRS_W{1'b0}}};
  assign sx    = {1'b0, s2_al};
  assign sum_c = s2_sub ? (lx - sx) : (lx + sx);

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_v <= 1'b0;
      s3_x <= 1'b0;
    end else begin
      s3_v <= s2_v;
      s3_x <= s2_x;
    end
    s3_r   <= s2_r;
    s3_ls  <= s2_ls;
    s3_le  <= s2_le;
    s3_sum <= sum_c;
  end

  // stage 4: correction - a zero sum becomes +0 with exponent 0
  logic zero_c;
  assign zero_c = ~|s3_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      exc_o <= 1'b0;
    end else begin
      vld_o <= s3_v;
      exc_o <= s3_x;
    end
    rnd_o  <= s3_r;
    sign_o <= zero_c ? 1'b0 : s3_ls;
    exp_o  <= zero_c ? '0 : s3_le;
    sum_o  <= s3_sum;
  end
endmodule

// File: rtl/fpadd_round_norm.sv
module fpadd_round_norm
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_i,
  input  logic                   exc_i,
  input  logic                   rnd_i,
  input  logic                   sign_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [MAN_W+GRS_W+1:0] sum_i,
  output logic                   vld_o,
  output logic                   exc_o,
  output logic [EXP_W+MAN_W:0]   res_o
);
  localparam int WS   = MAN_W + GRS_W + 2;
  localparam int LZW  = $clog2(WS + 1);
  localparam int XW   = EXP_W + LZW + 2;
  localparam int EMAX = (1 << EXP_W) - 1;
  localparam logic signed [XW-1:0] EMAX_X = XW'(EMAX);
  localparam logic signed [XW-1:0] ONE_X  = XW'(1);

  // stage 1: leading-zero count and left shift
  logic [LZW-1:0]         lz;
  logic [WS-1:0]          sh_c;
  logic signed [XW-1:0]   e_c;
  logic                   r1_v, r1_x, r1_r, r1_s;
  logic [WS-1:0]          r1_sh;
  logic signed [XW-1:0]   r1_e;

  always_comb begin
    lz = LZW'(WS);
    for (int i = 0; i < WS; i++) begin
      if (sum_i[i]) lz = LZW'(WS - 1 - i);
    end
    sh_c = sum_i << lz;
    e_c  = XW'(exp_i) + ONE_X - XW'(lz);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1_v <= 1'b0;
      r1_x <= 1'b0;
    end else begin
      r1_v <= vld_i;
      r1_x <= exc_i;
    end
    r1_r  <= rnd_i;
    r1_s  <= sign_i;
    r1_sh <= sh_c;
    r1_e  <= e_c;
  end

  // stage 2: round, detect range errors, pack
  logic [MAN_W-1:0]     frac;
  logic                 guard, sticky, inc;
  logic [MAN_W:0]       mr;
  logic signed [XW-1:0] e_r;
  logic                 x_c;
  logic [EXP_W+MAN_W:0] res_c;

  always_comb begin
    frac   = r1_sh[WS-2 -: MAN_W];
    guard  = r1_sh[GRS_W];
    sticky = |r1_sh[GRS_W-1:0];
    inc    = (r1_r == RND_NEAR) & guard & (sticky | frac[0]);
    mr     = {1'b0, frac} + {{MAN_W{1'b0}}, inc};
    e_r    = r1_e + XW'(mr[MAN_W]);
    x_c    = r1_x;
    res_c  = {r1_s, e_r[EXP_W-1:0], mr[MAN_W-1:0]};
    if (!r1_sh[WS-1]) begin
      res_c = '0;
    end else if (r1_e < ONE_X) begin
      res_c = '0;
      x_c   = 1'b1;
    end else if (e_r > EMAX_X) begin
      res_c = {r1_s, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
      x_c   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      exc_o <= 1'b0;
    end else begin
      vld_o <= r1_v;
      exc_o <= r1_v & x_c;
    end
    res_o <= res_c;
  end
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ready_i,
  input  logic                   exc_i,
  input  logic                   sub_i,
  input  logic                   rnd_i,
  input  logic [EXP_W+MAN_W:0]   op_a_i,
  input  logic [EXP_W+MAN_W:0]   op_b_i,
  output logic                   done_o,
  output logic                   exc_o,
  output logic [EXP_W+MAN_W:0]   sum_o
);
  localparam int W  = 1 + EXP_W + MAN_W;
  localparam int WS = MAN_W + GRS_W + 2;

  logic [W-1:0]     ops  [2];
  logic             sgn  [2];
  logic [EXP_W-1:0] ex   [2];
  logic [MAN_W:0]   mn   [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    fpadd_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .op_i   (ops[g]),
      .sign_o (sgn[g]),
      .exp_o  (ex[g]),
      .mant_o (mn[g])
    );
  end

  logic             b_sign;
  logic             a_v, a_x, a_r, a_s;
  logic [EXP_W-1:0] a_e;
  logic [WS-1:0]    a_sum;

  assign b_sign = sgn[1] ^ sub_i;

  fpadd_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_add (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (ready_i),
    .exc_i  (exc_i),
    .rnd_i  (rnd_i),
    .sa_i   (sgn[0]),
    .ea_i   (ex[0]),
    .ma_i   (mn[0]),
    .sb_i   (b_sign),
    .eb_i   (ex[1]),
    .mb_i   (mn[1]),
    .vld_o  (a_v),
    .exc_o  (a_x),
    .rnd_o  (a_r),
    .sign_o (a_s),
    .exp_o  (a_e),
    .sum_o  (a_sum)
  );

  fpadd_round_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rnd (
    .clk    (clk),
    .rst    (rst),
    .vld_i  (a_v),
    .exc_i  (a_x),
    .rnd_i  (a_r),
    .sign_i (a_s),
    .exp_i  (a_e),
    .sum_i  (a_sum),
    .vld_o  (done_o),
    .exc_o  (exc_o),
    .res_o  (sum_o)
  );
endmodule

// File: rtl/fpadd_pipe_checker.sv
module fpadd_pipe_checker #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ready_i,
  input logic                 exc_i,
  input logic [EXP_W+MAN_W:0] op_a_i,
  input logic [EXP_W+MAN_W:0] op_b_i,
  input logic                 done_o,
  input logic                 exc_o,
  input logic [EXP_W+MAN_W:0] sum_o
);
  localparam int W = 1 + EXP_W + MAN_W;

  logic [3:0] since_rst;
  logic       hist_ok;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
  end
  assign hist_ok = since_rst >= 4'd6;

  assert_done_latency_R3: assert property (@(posedge clk) disable iff (rst)
    hist_ok |-> (done_o == $past(ready_i, 6)));

  assert_exc_travels_R10: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(ready_i && exc_i, 6)) |-> exc_o);

  assert_zero_word_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && (sum_o[W-2 -: EXP_W] == '0)) |-> (sum_o == '0));

  assert_zero_operands_R2: assert property (@(posedge clk) disable iff (rst)
    (hist_ok && $past(ready_i && (op_a_i[W-2 -: EXP_W] == '0)
                              && (op_b_i[W-2 -: EXP_W] == '0), 6)) |-> (sum_o == '0));

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (!done_o && !exc_o));
endmodule

bind fpadd_pipe fpadd_pipe_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ready_i (ready_i),
  .exc_i   (exc_i),
  .op_a_i  (op_a_i),
  .op_b_i  (op_b_i),
  .done_o  (done_o),
  .exc_o   (exc_o),
  .sum_o   (sum_o)
);

// File: tb/fpadd_pipe_bench.sv
module fpadd_pipe_bench;
  localparam int EXP_W = 5;
  localparam int MAN_W = 6;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int LAT   = 6;
  localparam int EMAX  = (1 << EXP_W) - 1;
  localparam int QD    = 1024;

  logic         clk = 1'b0;
  logic         rst;
  logic         ready_i, exc_i, sub_i, rnd_i;
  logic [W-1:0] op_a_i, op_b_i;
  logic         done_o, exc_o;
  logic [W-1:0] sum_o;

  always #5 clk = ~clk;

  fpadd_pipe #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fpadd_pipe (
    .clk(clk), .rst(rst), .ready_i(ready_i), .exc_i(exc_i), .sub_i(sub_i),
    .rnd_i(rnd_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .done_o(done_o), .exc_o(exc_o), .sum_o(sum_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int head  = 0;
  int tail  = 0;
  bit ended = 1'b0;
  logic [W:0] exp_q [QD];
  int         iss_q [QD];
  string      tag_q [QD];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] mk(input bit s, input int e, input int f);
    return {s, EXP_W'(e), MAN_W'(f)};
  endfunction

  // exact integer model: returns {exception, word}
  function automatic logic [W:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input bit sub, input bit rnd, input bit exin);
    longint va, vb, sum, m, kept;
    int     ea, eb, p, er, sh;
    bit     s, g, st, inc;
    ea = int'(a[W-2 -: EXP_W]);
    eb = int'(b[W-2 -: EXP_W]);
    va = (ea == 0) ? 0 : (longint'({1'b1, a[MAN_W-1:0]}) << (ea - 1));
    vb = (eb == 0) ? 0 : (longint'({1'b1, b[MAN_W-1:0]}) << (eb - 1));
    if (a[W-1]) va = -va;
    if (b[W-1] ^ sub) vb = -vb;
    sum = va + vb;
    if (sum == 0) return {exin, {W{1'b0}}};
    s = sum < 0;
    m = s ? -sum : sum;
    p = 0;
    for (int i = 62; i >= 0; i--) begin
      if (m[i]) begin p = i; break; end
    end
    er = p - MAN_W + 1;
    if (er < 1) return {1'b1, {W{1'b0}}};
    sh   = p - MAN_W;
    kept = m >> sh;
    g  = 1'b0;
    st = 1'b0;
    if (sh > 0) begin
      g  = m[sh-1];
      st = (m & ((longint'(1) << (sh - 1)) - 1)) != 0;
    end
    inc = rnd && g && (st || kept[0]);
    kept = kept + longint'(inc);
    if ((kept >> (MAN_W + 1)) != 0) begin
      kept = kept >> 1;
      er   = er + 1;
    end
    if (er > EMAX) return {1'b1, s, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
    return {exin, s, EXP_W'(er), kept[MAN_W-1:0]};
  endfunction

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got exc=%b word=%h expected exc=%b word=%h",
               tag, act[W], act[W-1:0], exp[W], exp[W-1:0]);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue_x(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                         input bit rnd, input bit exin, input logic [W:0] exp,
                         input string tag);
    @(negedge clk);
    ready_i = 1'b1; op_a_i = a; op_b_i = b; sub_i = sub; rnd_i = rnd; exc_i = exin;
    exp_q[tail % QD] = exp;
    iss_q[tail % QD] = cyc;
    tag_q[tail % QD] = tag;
    tail++;
  endtask

  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub,
                       input bit rnd, input bit exin, input string tag);
    issue_x(a, b, sub, rnd, exin, ref_add(a, b, sub, rnd, exin), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ready_i = 1'b0;
      exc_i   = $urandom_range(0, 1) == 1;
      op_a_i  = W'($urandom);
      op_b_i  = W'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // scoreboard: result word, exception and latency (R3)
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (head == tail) begin
        n_chk++;
        n_bad++;
        $display("FAIL R3: got an unexpected done_o pulse, expected none");
      end else begin
        check(tag_q[head % QD], {exc_o, sum_o}, exp_q[head % QD]);
        check_int("R3 latency", cyc - iss_q[head % QD], LAT);
        head++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] a, b;
    int ea;
    void'($urandom(32'd20240611));
    rst = 1'b1; ready_i = 1'b0; exc_i = 1'b0; sub_i = 1'b0; rnd_i = 1'b0;
    op_a_i = '0; op_b_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11 done in reset", {1'b0, done_o}, '0);
    check("R11 exc in reset",  {1'b0, exc_o},  '0);
    rst = 1'b0;
    idle(2);
    check("R11 done after reset", {1'b0, done_o}, '0);

    // directed corners, hand-computed expectations
    issue_x(mk(0,15,0),    mk(0,14,0),    0, 1, 0, {1'b0, mk(0,15,6'h20)}, "R1 1.0+0.5");
    issue_x(mk(0,0,6'h2A), mk(0,16,5),    0, 1, 0, {1'b0, mk(0,16,5)},     "R2 zero-exp operand");
    issue_x(mk(1,0,6'h3F), mk(0,0,1),     0, 1, 0, {1'b0, {W{1'b0}}},      "R2 both zero");
    issue_x(mk(0,17,0),    mk(0,16,0),    1, 1, 0, {1'b0, mk(0,16,0)},     "R6 4-2");
    issue_x(mk(0,16,0),    mk(0,17,0),    1, 0, 0, {1'b0, mk(1,16,0)},     "R6 2-4");
    issue_x(mk(0,20,6'h15),mk(0,20,6'h15),1, 1, 0, {1'b0, {W{1'b0}}},      "R7 a-a");
    issue_x(mk(0,20,6'h15),mk(1,20,6'h15),0, 0, 0, {1'b0, {W{1'b0}}},      "R7 a+(-a)");
    issue_x(mk(0,1,1),     mk(0,1,0),     1, 1, 0, {1'b1, {W{1'b0}}},      "R8 underflow flush");
    issue_x(mk(0,31,6'h3F),mk(0,31,6'h3F),0, 1, 0, {1'b1, mk(0,31,6'h3F)}, "R9 overflow pos");
    issue_x(mk(1,31,6'h3F),mk(1,31,0),    0, 0, 0, {1'b1, mk(1,31,6'h3F)}, "R9 overflow neg");
    issue_x(mk(0,10,0),    mk(0,3,0),     0, 1, 0, {1'b0, mk(0,10,0)},     "R5 tie to even down");
    issue_x(mk(0,10,1),    mk(0,3,0),     0, 1, 0, {1'b0, mk(0,10,2)},     "R5 tie to even up");
    issue_x(mk(0,10,0),    mk(0,3,1),     0, 1, 0, {1'b0, mk(0,10,1)},     "R5 above half");
    issue_x(mk(0,10,1),    mk(0,3,0),     0, 0, 0, {1'b0, mk(0,10,1)},     "R4 tie truncated");
    issue_x(mk(0,10,6'h3F),mk(0,9,6'h3F), 0, 0, 0, {1'b0, mk(0,11,6'h1F)}, "R4 carry truncated");
    issue_x(mk(0,16,0),    mk(0,16,0),    0, 1, 1, {1'b1, mk(0,17,0)},     "R10 exception in");
    idle(10);

    // constrained random, mostly back-to-back
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 4) == 0) idle(1);
      a = W'($urandom);
      b = W'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        ea = int'(a[W-2 -: EXP_W]) + $urandom_range(0, 3) - 1;
        if (ea < 0) ea = 0;
        if (ea > EMAX) ea = EMAX;
        b[W-2 -: EXP_W] = EXP_W'(ea);
      end
      issue(a, b, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            $urandom_range(0, 15) == 0, "R1 random");
    end
    idle(12);
    check_int("R3 all results returned", head, tail);
    finish_run();
  end
endmodule